// File: doc/BRIEF.md
# DAC channel stream source controller

This block sits between a DMA-fed sample stream and the data path of a two-channel DAC. For every channel it picks what reaches the converter: the live stream, a value programmed through a small register port, or the most recent sample it accepted, held. A channel with nothing valid to send never drops to zero. Its output keeps the last level, which avoids spikes at buffer edges.

Both channels can be stopped on one clock edge by a shared suspend input, without touching the DMA. When channel synchronisation is on, both channels also start on the same edge, once every enabled channel has data. After a stop, samples left in the upstream FIFO can be drained and thrown away, so none of them leaks into the next transfer. A cyclic transfer ended by suspend with both channels enabled parks each output on its programmed value. A programmed value can also be sent on its own, with no stream running.

Each channel runs its own state machine with five states: idle, streaming, draining, holding and programmed-value. The outputs are registered.

Top module: `dac_src_ctrl`

## Requirements
- R1: During and after reset, out_valid is 0, out_data is 0 and s_ready is 0. The control word reads 0x3 (drain enable and synchronisation on, both programmed-value enables off), and the value word reads 0.
- R2: A write with cfg_addr 0x14 sets the control word. Bit 0 is drain enable, bit 1 is channel synchronisation, and bits 2 and 3 are the programmed-value enables of channels 0 and 1. A write to 0x19 sets the value word: bits 15:0 for channel 0 and bits 31:16 for channel 1. Both words read back on cfg_rdata with the address applied. Any other address reads 0 and ignores writes.
- R3: While a channel streams, a sample taken with s_valid and s_ready high at a clock edge appears on that channel's out_data from that edge on, and out_valid is 1.
- R4: While a channel streams and s_valid is low, its out_data keeps the last accepted sample instead of going to zero.
- R5: With synchronisation on, channels start only when every enabled channel has s_valid high and suspend is low. Their s_ready bits rise on the same edge.
- R6: With synchronisation on, asserting xfer_suspend stops both channels on the next edge. The sample offered in that cycle is not output.
- R7: With drain enabled, a stopped channel keeps s_ready high and discards every sample, leaving out_data unchanged. It drops s_ready on the second edge after s_valid goes low and stays low.
- R8: With drain disabled, a stopped channel drops s_ready on the stopping edge and holds its last sample.
- R9: A stop caused by suspend with synchronisation on and both channels enabled ends with each channel's out_data equal to its programmed value.
- R10: A parked channel whose programmed-value enable is set drives its programmed value, and follows later writes to it one edge after the write. With drain enabled, it first drains, with s_ready high, before the value appears.
- R11: With synchronisation off, xfer_suspend has no effect. A channel stops only when its ch_en bit goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the word at cfg_addr |
| xfer_suspend | input | 1 | Shared transfer suspend |
| ch_en | input | 2 | Per-channel enable |
| s_valid | input | 2 | Upstream sample valid, one bit per channel |
| s_data | input | 32 | Upstream samples, channel 0 in bits 15:0 |
| s_ready | output | 2 | Upstream ready, one bit per channel |
| out_valid | output | 2 | Output valid per channel |
| out_data | output | 32 | Registered output samples, channel 0 in bits 15:0 |

## Verification
The embedded properties check several rules on every cycle. Suspend with synchronisation on leaves no channel streaming. Parked channels with both enables set start together. A streamed sample lands on the output one edge after it is accepted. The output does not move while a channel drains or streams without valid data. A drain never ends while s_valid is high. Some behaviours need whole scenarios, which the bench drives: the reset readback, the register layout and unmapped addresses, the exact edge on which s_ready drops after a drain, the switch to programmed values after a suspended cyclic transfer, and the fact that suspend has no effect with synchronisation off. A random phase with varied valid patterns compares each output against a bench-side record of the last accepted sample.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STREAM = 3'd1,
    ST_FLUSH  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RAW    = 3'd4
  } src_state_e;
endpackage

// File: rtl/dac_src_regs.sv
module dac_src_regs
  import dac_src_pkg::*;
#(
  parameter int            DW         = 16,
  parameter int            AW         = 5,
  parameter logic [AW-1:0] CTRL_WADDR = 5'h14,
  parameter logic [AW-1:0] RAW_WADDR  = 5'h19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    flush_en,
  output logic                    sync_en,
  output logic [NCH-1:0]          raw_en,
  output logic [NCH-1:0][DW-1:0]  raw_val
);
  localparam int CTRL_W = 2 + NCH;

  logic [CTRL_W-1:0]         ctrl_q;
  logic                      ctrl_ld;
  logic                      raw_ld;
  logic [NCH-1:0][DW-1:0]    raw_q;

  assign ctrl_ld = we && (addr == CTRL_WADDR);
  assign raw_ld  = we && (addr == RAW_WADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_W'(2'b11);
    end else if (ctrl_ld) begin
      ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_raw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[c] <= '0;
      end else if (raw_ld) begin
        raw_q[c] <= wdata[c*DW +: DW];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_WADDR) begin
      rdata[CTRL_W-1:0] = ctrl_q;
    end else if (addr == RAW_WADDR) begin
      for (int c = 0; c < NCH; c++) begin
        rdata[c*DW +: DW] = raw_q[c];
      end
    end
  end

  assign flush_en = ctrl_q[0];
  assign sync_en  = ctrl_q[1];
  assign raw_en   = ctrl_q[CTRL_W-1:2];
  assign raw_val  = raw_q;

  // R2: a write to an unmapped address leaves both words untouched
  p_unmapped_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != CTRL_WADDR && addr != RAW_WADDR) |=> ($stable(ctrl_q) && $stable(raw_q)));
endmodule

// File: rtl/dac_src_chan.sv
module dac_src_chan
  import dac_src_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          stop,
  input  logic          raw_hold,
  input  logic          flush_en,
  input  logic          raw_en,
  input  logic [DW-1:0] raw_val,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          streaming,
  output logic          parked
);
  src_state_e    st_q, st_d;
  src_state_e    tgt_q, tgt_d;
  logic          quiet_q, quiet_d;
  logic [DW-1:0] out_q, out_d;
  logic          out_ld;
  logic          capture;
  logic          vld_q, vld_d;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    unique case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (raw_en) begin
          if (flush_en) begin
            st_d  = ST_FLUSH;
            tgt_d = ST_RAW;
          end else begin
            st_d = ST_RAW;
          end
        end else if (go) begin
          st_d = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (stop) begin
          tgt_d = (raw_hold || raw_en) ? ST_RAW : ST_HOLD;
          st_d  = flush_en ? ST_FLUSH : tgt_d;
        end
      end
      ST_FLUSH: begin
        if (quiet_q && !s_valid) begin
          st_d = tgt_q;
        end
      end
      ST_RAW: begin
        if (!raw_en) begin
          st_d = ST_HOLD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign capture = (st_q == ST_STREAM) && s_valid && !stop;
  assign out_ld  = (st_d == ST_RAW) || capture;
  assign out_d   = (st_d == ST_RAW) ? raw_val : s_data;
  assign quiet_d = (st_q == ST_FLUSH) && !s_valid;
  assign vld_d   = (st_d != ST_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tgt_q   <= ST_HOLD;
      quiet_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      quiet_q <= quiet_d;
      vld_q   <= vld_d;
    end
  end

  // output sample register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_ld) begin
      out_q <= out_d;
    end
  end

  assign s_ready   = (st_q == ST_STREAM) || (st_q == ST_FLUSH);
  assign out_data  = out_q;
  assign out_valid = vld_q;
  assign streaming = (st_q == ST_STREAM);
  assign parked    = (st_q == ST_IDLE) || (st_q == ST_HOLD);

  // R3: an accepted streamed sample is the output one edge later
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && s_valid && s_ready && !stop) |=> (out_data == $past(s_data)));

  // R4: streaming without valid data keeps the output level
  p_hold_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && !s_valid) |=> ($stable(out_data) || st_q == ST_RAW));

  // R7: draining discards data, the output does not move
  p_flush_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH) |=> ($stable(out_data) || st_q == ST_RAW));

  // R7: a drain never ends while the upstream still offers data
  p_flush_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH && s_valid) |=> (st_q == ST_FLUSH));
endmodule

// File: rtl/dac_src_ctrl.sv
module dac_src_ctrl
  import dac_src_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              xfer_suspend,
  input  logic [1:0]        ch_en,
  input  logic [1:0]        s_valid,
  input  logic [2*DW-1:0]   s_data,
  output logic [1:0]        s_ready,
  output logic [1:0]        out_valid,
  output logic [2*DW-1:0]   out_data
);
  logic                   rst_s1_q, rst_s2_q;
  logic                   rst_int_n;
  logic                   flush_en, sync_en;
  logic [NCH-1:0]         raw_en;
  logic [NCH-1:0][DW-1:0] raw_val;
  logic                   start_all;
  logic                   raw_hold;
  logic [NCH-1:0]         go, stop;
  logic [NCH-1:0]         streaming, parked;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  dac_src_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .flush_en (flush_en),
    .sync_en  (sync_en),
    .raw_en   (raw_en),
    .raw_val  (raw_val)
  );

  // shared start and stop decisions
  assign start_all = !xfer_suspend && (|ch_en) && (&(s_valid | ~ch_en));
  assign raw_hold  = sync_en && xfer_suspend && (&ch_en);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign stop[c] = !ch_en[c] || (sync_en && xfer_suspend);
    assign go[c]   = ch_en[c] && (sync_en ? start_all : s_valid[c]);

    dac_src_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .go        (go[c]),
      .stop      (stop[c]),
      .raw_hold  (raw_hold),
      .flush_en  (flush_en),
      .raw_en    (raw_en[c]),
      .raw_val   (raw_val[c]),
      .s_valid   (s_valid[c]),
      .s_data    (s_data[c*DW +: DW]),
      .s_ready   (s_ready[c]),
      .out_data  (out_data[c*DW +: DW]),
      .out_valid (out_valid[c]),
      .streaming (streaming[c]),
      .parked    (parked[c])
    );
  end

  // R6: suspend with synchronisation leaves no channel streaming
  p_sync_stop_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sync_en && xfer_suspend) |=> (streaming == '0));

  // R5: parked channels, both enabled, start on the same edge
  p_sync_start_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sync_en && (&ch_en) && (&parked) && raw_en == '0) |=> (streaming == '0 || (&streaming)));

  // R11: without synchronisation suspend alone never stops a stream
  p_suspend_ignored_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sync_en && xfer_suspend && streaming[0] && ch_en[0]) |=> streaming[0]);
endmodule

// File: tb/sim_dac_src_ctrl.sv
module sim_dac_src_ctrl;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          xfer_suspend;
  logic [1:0]    ch_en;
  logic [1:0]    s_valid;
  logic [31:0]   s_data;
  logic [1:0]    s_ready;
  logic [1:0]    out_valid;
  logic [31:0]   out_data;

  int            checks = 0;
  int            errors = 0;
  logic [1:0]    track = 2'b00;
  logic [15:0]   expv [2];
  logic [31:0]   seed_dummy;

  always #2 clk = ~clk;

  dac_src_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .xfer_suspend (xfer_suspend),
    .ch_en        (ch_en),
    .s_valid      (s_valid),
    .s_data       (s_data),
    .s_ready      (s_ready),
    .out_valid    (out_valid),
    .out_data     (out_data)
  );

  function automatic logic [15:0] lane(logic [31:0] v, int c);
    return v[c*16 +: 16];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: record what the bench expects the design to take
  task automatic step();
    logic [1:0] acc;
    acc = s_valid & s_ready & track;
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      if (acc[c]) expv[c] = lane(s_data, c);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    cfg_addr = a;
    #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic chk_out(string req, int c);
    chk(req, {16'h0, lane(out_data, c)}, {16'h0, expv[c]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd7);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    xfer_suspend = 1'b0; ch_en = 2'b00; s_valid = 2'b00; s_data = '0;
    expv[0] = '0; expv[1] = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 out_valid", {30'h0, out_valid}, 32'h0);
    chk("R1 out_data", out_data, 32'h0);
    chk("R1 s_ready", {30'h0, s_ready}, 32'h0);
    rst_n = 1'b1;
    repeat (4) step();
    rd_chk("R1 ctrl default", 5'h14, 32'h3);
    rd_chk("R1 value default", 5'h19, 32'h0);

    // R2 register layout
    wr(5'h19, 32'h5678_1234);
    rd_chk("R2 value word", 5'h19, 32'h5678_1234);
    wr(5'h03, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped read", 5'h03, 32'h0);
    rd_chk("R2 ctrl untouched", 5'h14, 32'h3);
    rd_chk("R2 value untouched", 5'h19, 32'h5678_1234);

    // R5 synchronised start
    ch_en = 2'b11; s_valid = 2'b01; s_data = 32'h1111_2222;
    step();
    chk("R5 no start, ch1 empty", {30'h0, s_ready}, 32'h0);
    step();
    chk("R5 still waiting", {30'h0, s_ready}, 32'h0);
    s_valid = 2'b11;
    step();
    chk("R5 joint start", {30'h0, s_ready}, 32'h3);
    track = 2'b11;
    step();
    chk_out("R3 first sample ch0", 0);
    chk_out("R3 first sample ch1", 1);

    // R3/R4 random stream
    for (int i = 0; i < 300; i++) begin
      logic [1:0] v;
      v = 2'($urandom());
      s_valid = v;
      s_data = $urandom();
      step();
      for (int c = 0; c < 2; c++) begin
        if (v[c]) chk_out("R3 streamed sample", c);
        else      chk_out("R4 held sample", c);
      end
      chk("R3 out_valid", {30'h0, out_valid}, 32'h3);
    end

    // R6/R7/R9 suspend, drain, programmed value
    track = 2'b00;
    xfer_suspend = 1'b1; s_valid = 2'b11; s_data = 32'hDEAD_BEEF;
    step();
    chk("R6 stop sample not output ch0", {16'h0, lane(out_data, 0)}, {16'h0, expv[0]});
    chk("R6 stop sample not output ch1", {16'h0, lane(out_data, 1)}, {16'h0, expv[1]});
    chk("R7 ready during drain", {30'h0, s_ready}, 32'h3);
    for (int i = 0; i < 3; i++) begin
      s_data = $urandom();
      step();
      chk_out("R7 discard ch0", 0);
      chk_out("R7 discard ch1", 1);
      chk("R7 ready kept", {30'h0, s_ready}, 32'h3);
    end
    s_valid = 2'b00;
    step();
    chk("R7 ready after one quiet cycle", {30'h0, s_ready}, 32'h3);
    step();
    chk("R7 ready dropped", {30'h0, s_ready}, 32'h0);
    chk("R9 programmed value", out_data, 32'h5678_1234);
    step();
    chk("R9 value kept", out_data, 32'h5678_1234);
    chk("R9 out_valid", {30'h0, out_valid}, 32'h3);

    // restart
    expv[0] = 16'h1234; expv[1] = 16'h5678;
    xfer_suspend = 1'b0; s_valid = 2'b11; s_data = 32'hA0A0_B0B0;
    step();
    chk("R5 restart", {30'h0, s_ready}, 32'h3);
    track = 2'b11;
    step();
    chk_out("R3 after restart ch0", 0);
    chk_out("R3 after restart ch1", 1);

    // R11 suspend ignored without synchronisation, drain off
    wr(5'h14, 32'h0);
    xfer_suspend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      s_data = $urandom();
      step();
      chk_out("R11 suspend ignored ch0", 0);
      chk_out("R11 suspend ignored ch1", 1);
      chk("R11 ready kept", {30'h0, s_ready}, 32'h3);
    end

    // R8 stop through ch_en with drain disabled
    track = 2'b10;
    ch_en = 2'b10; s_data = 32'h7777_9999;
    step();
    chk("R8 ready dropped at once", {30'h0, s_ready}, 32'h2);
    chk_out("R8 held ch0", 0);
    chk_out("R11 ch1 continues", 1);
    s_data = 32'h3333_4444;
    step();
    chk_out("R8 still held ch0", 0);

    // R10 programmed value with drain
    xfer_suspend = 1'b0;
    s_valid = 2'b10;
    wr(5'h14, 32'h5);
    step();
    chk("R10 drain first", {31'h0, s_ready[0]}, 32'h1);
    step();
    chk("R10 drain waits quiet", {31'h0, s_ready[0]}, 32'h1);
    step();
    chk("R10 drain done", {31'h0, s_ready[0]}, 32'h0);
    chk("R10 value shown", {16'h0, lane(out_data, 0)}, 32'h1234);
    wr(5'h19, 32'h5678_BEEF);
    step();
    chk("R10 follows write", {16'h0, lane(out_data, 0)}, 32'hBEEF);
    chk_out("R3 ch1 unaffected", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule